// File: doc/BRIEF.md
# Comparator-Status Lookup Output Sequencer

This block turns four comparator decisions into a four-bit fault or status code on general-purpose output pins. It runs a free loop: it samples the synchronized comparator bits, applies a per-channel polarity flip, uses the resulting four-bit pattern to select one of sixteen programmable entries, and drives the pins with that entry. It then idles for a programmable time before the next pass, so that the pins do not chatter while the analog inputs settle.

A narrow write port loads the sixteen table entries, a five-bit wait code and a three-bit run field. Software halts the loop, changes the settings and starts the loop again. Each pin is meant for an open-drain pad, so the block also provides a per-pin pull-low enable.

The wait time scales with a parameterised prescaler. With the default divide of 256 250 cycles at 125 MHz, one tick is 2.05 ms, and a wait code of 19 gives 41 ms between passes.

Top module: `cmp_lut_seq`

## Requirements
- R1: After reset `gpo` is 0, `gpo_pull_low` is all ones, `wr_err` is 0, the loop is halted, and all table entries and the wait code are 0. Starting the loop without loading the table therefore keeps `gpo` at 0.
- R2: The table index is {CMP3, CMP2, CMP1, CMP0}, taken from `cmp_raw[3:0]` with bit 3 as the MSB. While the loop runs, `gpo` settles to table entry [index].
- R3: When `inv_en[k]` is 1, bit k of the index is the complement of the synchronized `cmp_raw[k]`. When `inv_en[k]` is 0, bit k is taken unchanged.
- R4: While the loop runs, consecutive output updates are exactly (wait_code + 1) × TICK_DIV + 2 clock cycles apart.
- R5: The loop runs only while the run field holds 3. Any other value halts it, and `gpo` then holds its last value whatever the comparator inputs do.
- R6: A write to a table entry or to the wait code is ignored while the loop is running or still winding down, and it sets `wr_err`. `wr_err` stays set until reset. The same writes made while the loop is halted take effect.
- R7: `gpo` changes only on the clock edge that ends the update step of a pass, never at any other time.
- R8: `gpo_pull_low[k]` is 1 exactly when `gpo[k]` is 0.
- R9: The write address map is: table entries at addresses 0–15, wait code at 16, run field at 17. Writes to addresses 18–31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 4 | Comparator results, asynchronous to `clk` |
| inv_en | input | 4 | Per-channel polarity flip |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 5 | Write data; entries use bits [3:0], the run field uses [2:0] |
| gpo | output | 4 | Selected code |
| gpo_pull_low | output | 4 | Per-pin pull-low enable for open-drain pads |
| wr_err | output | 1 | Sticky flag for rejected writes |

## Verification
The assertions check four properties on every cycle:
- the outputs move only at the end of an update step (R7) and hold while halted (R5);
- the table is frozen whenever the loop is busy (R6);
- a rejected write raises the sticky error flag (R6).

The bench's scenarios show the end-to-end behaviour that a single-cycle property cannot express:
- the index order and the table contents across every comparator pattern (R2);
- the inversion masks (R3);
- the exact spacing between updates for several wait codes (R4);
- the effect of writes made in the halted and running states (R6, R9).

// File: rtl/cmpseq_pkg.sv
package cmpseq_pkg;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_UPDATE = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_e;

    localparam int unsigned RUN_GO_CODE = 3;

endpackage

// File: rtl/cmpseq_sync.sv
module cmpseq_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = din;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.s2;

endmodule

// File: rtl/cmpseq_regs.sv
module cmpseq_regs #(
    parameter int NCMP   = 4,
    parameter int CODE_W = 4,
    parameter int WAIT_W = 5,
    parameter int RUN_W  = 3,
    parameter int DATA_W = 5,
    parameter int ADDR_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              busy,
    output logic [(1<<NCMP)-1:0][CODE_W-1:0]  tbl,
    output logic [WAIT_W-1:0]                 wait_code,
    output logic [RUN_W-1:0]                  run_field,
    output logic                              wr_err
);

    localparam int DEPTH = 1 << NCMP;
    localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][CODE_W-1:0] tbl;
        logic [WAIT_W-1:0]            wait_code;
        logic [RUN_W-1:0]             run_field;
        logic                         err;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == A_RUN) begin
                regs_d.run_field = wr_data[RUN_W-1:0];
            end else if (wr_addr <= A_WAIT) begin
                if (busy) begin
                    regs_d.err = 1'b1;
                end else if (wr_addr == A_WAIT) begin
                    regs_d.wait_code = wr_data[WAIT_W-1:0];
                end else begin
                    regs_d.tbl[wr_addr[NCMP-1:0]] = wr_data[CODE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign tbl       = regs_q.tbl;
    assign wait_code = regs_q.wait_code;
    assign run_field = regs_q.run_field;
    assign wr_err    = regs_q.err;

endmodule

// File: rtl/cmpseq_seq.sv
module cmpseq_seq
    import cmpseq_pkg::*;
#(
    parameter int NCMP     = 4,
    parameter int CODE_W   = 4,
    parameter int WAIT_W   = 5,
    parameter int RUN_W    = 3,
    parameter int TICK_DIV = 256250
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NCMP-1:0]                   cmp_idx,
    input  logic [(1<<NCMP)-1:0][CODE_W-1:0]  tbl,
    input  logic [WAIT_W-1:0]                 wait_code,
    input  logic [RUN_W-1:0]                  run_field,
    output logic [CODE_W-1:0]                 gpo,
    output logic                              busy,
    output seq_state_e                        state
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [NCMP-1:0]   idx;
        logic [PRE_W-1:0]  pre;
        logic [WAIT_W-1:0] tcnt;
        logic [CODE_W-1:0] gpo;
    } seq_t;

    seq_t seq_d, seq_q;
    logic go;

    always_comb begin
        go    = (run_field == RUN_W'(RUN_GO_CODE));
        seq_d = seq_q;
        if (!go) begin
            seq_d.state = ST_HALT;
        end else begin
            unique case (seq_q.state)
                ST_HALT: begin
                    seq_d.state = ST_SAMPLE;
                end
                ST_SAMPLE: begin
                    seq_d.idx   = cmp_idx;
                    seq_d.state = ST_UPDATE;
                end
                ST_UPDATE: begin
                    seq_d.gpo   = tbl[seq_q.idx];
                    seq_d.pre   = '0;
                    seq_d.tcnt  = '0;
                    seq_d.state = ST_WAIT;
                end
                ST_WAIT: begin
                    if (seq_q.pre == PRE_LAST) begin
                        seq_d.pre = '0;
                        if (seq_q.tcnt == wait_code) seq_d.state = ST_SAMPLE;
                        else                         seq_d.tcnt  = seq_q.tcnt + 1'b1;
                    end else begin
                        seq_d.pre = seq_q.pre + 1'b1;
                    end
                end
                default: seq_d.state = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: ST_HALT, default: '0};
        else        seq_q <= seq_d;
    end

    assign gpo   = seq_q.gpo;
    assign busy  = go || (seq_q.state != ST_HALT);
    assign state = seq_q.state;

endmodule

// File: rtl/cmp_lut_seq.sv
module cmp_lut_seq
    import cmpseq_pkg::*;
#(
    parameter int NCMP     = 4,
    parameter int CODE_W   = 4,
    parameter int WAIT_W   = 5,
    parameter int RUN_W    = 3,
    parameter int TICK_DIV = 256250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmp_raw,
    input  logic [3:0]        inv_en,
    input  logic              wr_en,
    input  logic [4:0]        wr_addr,
    input  logic [4:0]        wr_data,
    output logic [3:0]        gpo,
    output logic [3:0]        gpo_pull_low,
    output logic              wr_err
);

    localparam int DEPTH  = 1 << NCMP;
    localparam int ADDR_W = $clog2(DEPTH + 2);
    localparam int MAX_CR = (CODE_W > RUN_W) ? CODE_W : RUN_W;
    localparam int DATA_W = (WAIT_W > MAX_CR) ? WAIT_W : MAX_CR;

    logic [NCMP-1:0]              cmp_sync;
    logic [NCMP-1:0]              cmp_idx;
    logic [DEPTH-1:0][CODE_W-1:0] tbl;
    logic [WAIT_W-1:0]            wait_code;
    logic [RUN_W-1:0]             run_field;
    logic                         busy;
    seq_state_e                   seq_state;

    cmpseq_sync #(.W(NCMP)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_raw),
        .dout (cmp_sync)
    );

    assign cmp_idx = cmp_sync ^ inv_en;

    cmpseq_regs #(
        .NCMP(NCMP), .CODE_W(CODE_W), .WAIT_W(WAIT_W),
        .RUN_W(RUN_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .busy     (busy),
        .tbl      (tbl),
        .wait_code(wait_code),
        .run_field(run_field),
        .wr_err   (wr_err)
    );

    cmpseq_seq #(
        .NCMP(NCMP), .CODE_W(CODE_W), .WAIT_W(WAIT_W),
        .RUN_W(RUN_W), .TICK_DIV(TICK_DIV)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmp_idx  (cmp_idx),
        .tbl      (tbl),
        .wait_code(wait_code),
        .run_field(run_field),
        .gpo      (gpo),
        .busy     (busy),
        .state    (seq_state)
    );

    assign gpo_pull_low = ~gpo;

endmodule

// File: rtl/cmp_lut_seq_chk.sv
module cmp_lut_seq_chk
    import cmpseq_pkg::*;
#(
    parameter int NCMP   = 4,
    parameter int CODE_W = 4,
    parameter int ADDR_W = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              wr_en,
    input logic [ADDR_W-1:0]                 wr_addr,
    input logic                              busy,
    input seq_state_e                        state,
    input logic [(1<<NCMP)-1:0][CODE_W-1:0]  tbl,
    input logic [CODE_W-1:0]                 gpo,
    input logic                              wr_err
);

    localparam logic [ADDR_W-1:0] A_WAIT = ADDR_W'(1 << NCMP);

    // R7: outputs move only after an update step
    a_r7_gpo_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_UPDATE) |=> $stable(gpo));

    // R5: outputs hold while halted
    a_r5_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> $stable(gpo));

    // R6: table frozen while busy
    a_r6_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tbl));

    // R6: rejected write raises the flag
    a_r6_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && (wr_addr <= A_WAIT)) |=> wr_err);

    // R6: flag is sticky
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R4: a sample step is always followed by an update step or a halt
    a_r4_sample_then_update: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SAMPLE) |=> (state == ST_UPDATE || state == ST_HALT));

endmodule

bind cmp_lut_seq cmp_lut_seq_chk #(
    .NCMP(NCMP), .CODE_W(CODE_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .busy   (busy),
    .state  (seq_state),
    .tbl    (tbl),
    .gpo    (gpo),
    .wr_err (wr_err)
);

// File: tb/cmp_lut_seq_tb.sv
module cmp_lut_seq_tb;

    localparam int TDIV   = 4;
    localparam int A_WAIT = 16;
    localparam int A_RUN  = 17;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] cmp_raw, inv_en;
    logic       wr_en;
    logic [4:0] wr_addr, wr_data;
    logic [3:0] gpo, gpo_pull_low;
    logic       wr_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;
    int exp_tbl [16];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cmp_lut_seq #(.TICK_DIV(TDIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .inv_en(inv_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gpo(gpo), .gpo_pull_low(gpo_pull_low), .wr_err(wr_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 5'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (40) @(negedge clk);
    endtask

    task automatic measure(input int code);
        int a, b, t1, t2;
        a = -1; b = -1;
        wr(A_RUN, 0);
        wr(A_WAIT, code);
        for (int i = 0; i < 16; i++) if (a < 0 && exp_tbl[i] != int'(gpo)) a = i;
        for (int i = 0; i < 16; i++) if (b < 0 && a >= 0 && exp_tbl[i] != exp_tbl[a]) b = i;
        cmp_raw = 4'(a);
        repeat (5) @(negedge clk);
        wr(A_RUN, 3);
        while (int'(gpo) != exp_tbl[a]) @(negedge clk);
        t1 = cyc;
        cmp_raw = 4'(b);
        while (int'(gpo) != exp_tbl[b]) @(negedge clk);
        t2 = cyc;
        chk((t2 - t1) == (code + 1) * TDIV + 2, "R4 update spacing", t2 - t1, (code + 1) * TDIV + 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int keep, v;
        rst_n = 1'b0; cmp_raw = '0; inv_en = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(gpo == 4'h0, "R1 gpo reset", gpo, 0);
        chk(gpo_pull_low == 4'hF, "R1 pull_low reset", gpo_pull_low, 15);
        chk(wr_err == 1'b0, "R1 err reset", wr_err, 0);

        // R1 empty table after reset
        cmp_raw = 4'hF;
        wr(A_RUN, 3);
        settle();
        chk(gpo == 4'h0, "R1 zero table", gpo, 0);
        wr(A_RUN, 0);
        repeat (4) @(negedge clk);

        // R9 table at 0..15, wait at 16
        for (int i = 0; i < 16; i++) begin
            exp_tbl[i] = (i * 5 + 3) & 15;
            wr(i, exp_tbl[i]);
        end
        wr(A_WAIT, 1);
        wr(A_RUN, 3);

        // R2 / R8 sweep
        for (int c = 0; c < 16; c++) begin
            cmp_raw = 4'(c);
            settle();
            chk(int'(gpo) == exp_tbl[c], "R2 lookup", gpo, exp_tbl[c]);
            chk(gpo_pull_low == ~gpo, "R8 pull_low", gpo_pull_low, int'(~gpo));
        end

        // R3 inversion sweeps
        for (int p = 0; p < 2; p++) begin
            inv_en = (p == 0) ? 4'b1001 : 4'b0110;
            for (int c = 0; c < 16; c++) begin
                cmp_raw = 4'(c);
                settle();
                chk(int'(gpo) == exp_tbl[c ^ int'(inv_en)], "R3 inversion", gpo, exp_tbl[c ^ int'(inv_en)]);
            end
        end
        inv_en = 4'b0000;

        // R6 writes while running are ignored
        cmp_raw = 4'd5;
        settle();
        keep = int'(gpo);
        wr(5, keep ^ 15);
        wr(A_WAIT, 7);
        settle();
        chk(int'(gpo) == exp_tbl[5], "R6 ignored table write", gpo, exp_tbl[5]);
        chk(wr_err == 1'b1, "R6 err set", wr_err, 1);

        // R9 high address has no effect
        wr(20, 0);
        cmp_raw = 4'd6;
        settle();
        chk(int'(gpo) == exp_tbl[6], "R9 high address ignored", gpo, exp_tbl[6]);

        // R5 halt and hold
        wr(A_RUN, 0);
        repeat (5) @(negedge clk);
        cmp_raw = 4'd9;
        settle();
        chk(int'(gpo) == exp_tbl[6], "R5 hold on halt", gpo, exp_tbl[6]);
        wr(A_RUN, 5);
        settle();
        chk(int'(gpo) == exp_tbl[6], "R5 run=5 halts", gpo, exp_tbl[6]);

        // R6 write accepted when halted, flag sticky
        v = exp_tbl[9] ^ 5;
        exp_tbl[9] = v;
        wr(9, v);
        wr(A_RUN, 3);
        settle();
        chk(int'(gpo) == v, "R6 halted write accepted", gpo, v);
        chk(wr_err == 1'b1, "R6 err sticky", wr_err, 1);

        // R4 spacing
        measure(0);
        measure(2);
        measure(5);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule